// File: doc/BRIEF.md
# Graphics Engine Interrupt Controller

This block gathers three interrupt causes of a graphics engine and drives one interrupt request line. The three causes are a pulse at the end of a binning flush, a pulse at the end of a rendered frame, and a level that stays high while the binner has run out of memory. A status register keeps each cause pending until software acknowledges it. Software acknowledges a cause by writing a one to its status bit.

Enables have no read/write mask. Software changes them through two strobe registers. Writing ones to the set register turns enables on, and writing ones to the clear register turns them off. In both registers, zero bits leave the enables as they are. The request line is the registered OR of all pending causes that are enabled.

A plain bus with address, write strobe, write data and combinational read data gives access to the three registers. Register offsets are parameters, with defaults 0x0, 0x4 and 0x8.

Top module: `gfx_irq_ctrl`

## Requirements
- R1: After reset, all pending bits are 0, all enables are 0 and `irq_req` is 0.
- R2: A read at offset 0x0 returns the pending bits: bit 0 is out of memory, bit 1 is flush done and bit 2 is frame done. Bits 31..3 read as 0.
- R3: A write at offset 0x0 clears each flush-done or frame-done pending bit whose data bit is 1. Pending bits whose data bit is 0 keep their value.
- R4: A write at offset 0x4 sets each enable whose data bit is 1. Enables whose data bit is 0 keep their value.
- R5: A write at offset 0x8 clears each enable whose data bit is 1. Enables whose data bit is 0 keep their value.
- R6: A read at offset 0x4 or at offset 0x8 returns the enable mask, with the same bit layout as R2.
- R7: While the out-of-memory level is high, pending bit 0 stays 1, even after a write of 1 to it. Once the level is low, a write of 1 clears bit 0.
- R8: On each clock, `irq_req` takes the OR of (pending AND enable) as it stood just before that edge. A change to pending bits or enables therefore reaches `irq_req` one cycle after it takes effect.
- R9: If a cause is active in the same cycle as a write-one clear of its pending bit, the bit stays 1.
- R10: A pending bit is captured even when its enable is 0. Enabling a bit that is already pending raises `irq_req` one cycle after the enable takes effect.
- R11: Writes to any offset other than 0x0, 0x4 or 0x8 change nothing, and reads at those offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (4) | Byte offset of the register |
| bus_wr | input | 1 | Write strobe; the write takes effect on the rising clock edge while this is high |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Combinational read data for `bus_addr` |
| flush_done_evt | input | 1 | One-cycle pulse at the end of a binning flush |
| frame_done_evt | input | 1 | One-cycle pulse at the end of a rendered frame |
| bin_oom_lvl | input | 1 | High while the binner is out of memory |
| irq_req | output | 1 | Interrupt request |

## Verification
The bench first applies single isolated pulses on each cause with the enables off and then on. This separates capture from delivery. Writes with mixed one and zero bits to each of the three registers show whether zero bits are really ignored, and a bulk acknowledge of all three bits tests the clear path for every source at once. Holding the out-of-memory level across an acknowledge and then dropping it separates the level source from the pulse sources. A pulse placed in the same cycle as its clear checks R9. A long pseudo-random stretch of mixed writes and events is then compared against the reference model on every clock.

// File: rtl/gfx_irq_pkg.sv
package gfx_irq_pkg;
   localparam int unsigned SRC_COUNT = 3;
   localparam int unsigned SRC_OOM   = 0;
   localparam int unsigned SRC_FLUSH = 1;
   localparam int unsigned SRC_FRAME = 2;

   typedef enum logic [1:0] {
      SEL_PEND  = 2'd0,
      SEL_ENSET = 2'd1,
      SEL_ENCLR = 2'd2,
      SEL_NONE  = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/gfx_irq_src_bit.sv
// One pending bit. LEVEL selects the level-held variant, where an
// acknowledge cannot drop the bit while the cause is still high.
module gfx_irq_src_bit #(
   parameter bit LEVEL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cause,
   input  logic ack,
   output logic pend
);
   logic pend_d;

   generate
      if (LEVEL) begin : g_level
         always_comb begin
            if (cause)
               pend_d = 1'b1;
            else if (ack)
               pend_d = 1'b0;
            else
               pend_d = pend;
         end
      end else begin : g_pulse
         // sticky capture; a fresh pulse beats a same-cycle acknowledge
         always_comb pend_d = cause | (pend & ~ack);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pend <= 1'b0;
      else
         pend <= pend_d;
   end
endmodule

// File: rtl/gfx_irq_enable.sv
module gfx_irq_enable #(
   parameter int unsigned WIDTH = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] set_mask,
   input  logic [WIDTH-1:0] clr_mask,
   output logic [WIDTH-1:0] en
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         en <= '0;
      else
         en <= (en | set_mask) & ~clr_mask;
   end
endmodule

// File: rtl/gfx_irq_regif.sv
module gfx_irq_regif
   import gfx_irq_pkg::*;
#(
   parameter int unsigned ADDR_W  = 4,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned NUM_SRC = 3,
   parameter logic [ADDR_W-1:0] PEND_OFS  = 'h0,
   parameter logic [ADDR_W-1:0] ENSET_OFS = 'h4,
   parameter logic [ADDR_W-1:0] ENCLR_OFS = 'h8
) (
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_wr,
   input  logic [DATA_W-1:0]  bus_wdata,
   input  logic [NUM_SRC-1:0] pend,
   input  logic [NUM_SRC-1:0] en,
   output logic [NUM_SRC-1:0] ack_mask,
   output logic [NUM_SRC-1:0] set_mask,
   output logic [NUM_SRC-1:0] clr_mask,
   output logic [DATA_W-1:0]  bus_rdata
);
   reg_sel_e sel;

   always_comb begin
      if (bus_addr == PEND_OFS)
         sel = SEL_PEND;
      else if (bus_addr == ENSET_OFS)
         sel = SEL_ENSET;
      else if (bus_addr == ENCLR_OFS)
         sel = SEL_ENCLR;
      else
         sel = SEL_NONE;
   end

   always_comb begin
      ack_mask = '0;
      set_mask = '0;
      clr_mask = '0;
      if (bus_wr) begin
         unique case (sel)
            SEL_PEND:  ack_mask = bus_wdata[NUM_SRC-1:0];
            SEL_ENSET: set_mask = bus_wdata[NUM_SRC-1:0];
            SEL_ENCLR: clr_mask = bus_wdata[NUM_SRC-1:0];
            default:   ;
         endcase
      end
   end

   always_comb begin
      bus_rdata = '0;
      unique case (sel)
         SEL_PEND:             bus_rdata[NUM_SRC-1:0] = pend;
         SEL_ENSET, SEL_ENCLR: bus_rdata[NUM_SRC-1:0] = en;
         default:              ;
      endcase
   end
endmodule

// File: rtl/gfx_irq_ctrl.sv
module gfx_irq_ctrl
   import gfx_irq_pkg::*;
#(
   parameter int unsigned ADDR_W  = 4,
   parameter int unsigned DATA_W  = 32,
   parameter logic [ADDR_W-1:0] PEND_OFS  = 'h0,
   parameter logic [ADDR_W-1:0] ENSET_OFS = 'h4,
   parameter logic [ADDR_W-1:0] ENCLR_OFS = 'h8,
   parameter logic [SRC_COUNT-1:0] LEVEL_MASK = 3'b001
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              flush_done_evt,
   input  logic              frame_done_evt,
   input  logic              bin_oom_lvl,
   output logic              irq_req
);
   localparam int unsigned NUM_SRC = SRC_COUNT;

   generate
      if (DATA_W < NUM_SRC) begin : g_bad_data_w
         $error("DATA_W must hold every source bit");
      end
      if ((PEND_OFS == ENSET_OFS) || (PEND_OFS == ENCLR_OFS) ||
          (ENSET_OFS == ENCLR_OFS)) begin : g_bad_ofs
         $error("register offsets must differ");
      end
   endgenerate

   logic [NUM_SRC-1:0] cause;
   logic [NUM_SRC-1:0] pend_q;
   logic [NUM_SRC-1:0] en_q;
   logic [NUM_SRC-1:0] ack_mask;
   logic [NUM_SRC-1:0] set_mask;
   logic [NUM_SRC-1:0] clr_mask;

   always_comb begin
      cause            = '0;
      cause[SRC_OOM]   = bin_oom_lvl;
      cause[SRC_FLUSH] = flush_done_evt;
      cause[SRC_FRAME] = frame_done_evt;
   end

   gfx_irq_regif #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SRC(NUM_SRC),
      .PEND_OFS(PEND_OFS), .ENSET_OFS(ENSET_OFS), .ENCLR_OFS(ENCLR_OFS)
   ) u_regif (
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .pend      (pend_q),
      .en        (en_q),
      .ack_mask  (ack_mask),
      .set_mask  (set_mask),
      .clr_mask  (clr_mask),
      .bus_rdata (bus_rdata)
   );

   genvar gi;
   generate
      for (gi = 0; gi < NUM_SRC; gi++) begin : g_src
         gfx_irq_src_bit #(.LEVEL(LEVEL_MASK[gi])) u_bit (
            .clk   (clk),
            .rst_n (rst_n),
            .cause (cause[gi]),
            .ack   (ack_mask[gi]),
            .pend  (pend_q[gi])
         );
      end
   endgenerate

   gfx_irq_enable #(.WIDTH(NUM_SRC)) u_en (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_mask (set_mask),
      .clr_mask (clr_mask),
      .en       (en_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         irq_req <= 1'b0;
      else
         irq_req <= |(pend_q & en_q);
   end
endmodule

// File: rtl/gfx_irq_ctrl_chk.sv
module gfx_irq_ctrl_chk #(
   parameter int unsigned ADDR_W  = 4,
   parameter int unsigned DATA_W  = 32,
   parameter logic [ADDR_W-1:0] PEND_OFS  = 'h0,
   parameter logic [ADDR_W-1:0] ENSET_OFS = 'h4,
   parameter logic [ADDR_W-1:0] ENCLR_OFS = 'h8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              flush_done_evt,
   input logic              frame_done_evt,
   input logic              bin_oom_lvl,
   input logic              irq_req,
   input logic [2:0]        pend,
   input logic [2:0]        en
);
   logic seen;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen <= 1'b0;
      else        seen <= 1'b1;
   end

   logic wr_pend, wr_set, wr_clr;
   assign wr_pend = bus_wr && (bus_addr == PEND_OFS);
   assign wr_set  = bus_wr && (bus_addr == ENSET_OFS);
   assign wr_clr  = bus_wr && (bus_addr == ENCLR_OFS);

   always @(posedge clk) begin
      if (!rst_n) begin
         p_reset_clear_r1: assert (pend == 3'b000 && en == 3'b000 && !irq_req)
            else $error("reset state wrong");
      end
   end

   p_irq_lags_r8: assert property (@(posedge clk) disable iff (!rst_n)
      seen |-> (irq_req == $past(|(pend & en))));

   p_event_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
      flush_done_evt |=> pend[1]);

   p_oom_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
      bin_oom_lvl |=> pend[0]);

   p_ack_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_pend && bus_wdata[2] && !frame_done_evt) |=> !pend[2]);

   p_flush_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_pend && !flush_done_evt) |=> $stable(pend[1]));

   p_enable_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_set && bus_wdata[0]) |=> en[0]);

   p_enable_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_clr && bus_wdata[1]) |=> !en[1]);

   p_enable_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_set && !wr_clr) |=> $stable(en));
endmodule

bind gfx_irq_ctrl gfx_irq_ctrl_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W),
   .PEND_OFS(PEND_OFS), .ENSET_OFS(ENSET_OFS), .ENCLR_OFS(ENCLR_OFS)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .bus_addr       (bus_addr),
   .bus_wr         (bus_wr),
   .bus_wdata      (bus_wdata),
   .flush_done_evt (flush_done_evt),
   .frame_done_evt (frame_done_evt),
   .bin_oom_lvl    (bin_oom_lvl),
   .irq_req        (irq_req),
   .pend           (pend_q),
   .en             (en_q)
);

// File: tb/gfx_irq_ctrl_test.sv
`timescale 1ns/1ps
module gfx_irq_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        flush_done_evt = 1'b0;
   logic        frame_done_evt = 1'b0;
   logic        bin_oom_lvl = 1'b0;
   logic        irq_req;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;  // 125 MHz

   gfx_irq_ctrl uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .flush_done_evt(flush_done_evt), .frame_done_evt(frame_done_evt),
      .bin_oom_lvl(bin_oom_lvl), .irq_req(irq_req)
   );

   // behavioural reference model
   logic [2:0] m_pend = '0;
   logic [2:0] m_en   = '0;
   logic       m_irq  = 1'b0;

   always @(posedge clk) begin
      logic [2:0] ack, setm, clrm, hit;
      logic       nirq;
      if (!rst_n) begin
         m_pend = '0; m_en = '0; m_irq = 1'b0;
      end else begin
         nirq = 1'b0;
         for (int k = 0; k < 3; k++) if (m_pend[k] && m_en[k]) nirq = 1'b1;
         ack = '0; setm = '0; clrm = '0;
         if (bus_wr && bus_addr == 4'h0) ack  = bus_wdata[2:0];
         if (bus_wr && bus_addr == 4'h4) setm = bus_wdata[2:0];
         if (bus_wr && bus_addr == 4'h8) clrm = bus_wdata[2:0];
         hit = {frame_done_evt, flush_done_evt, bin_oom_lvl};
         for (int k = 0; k < 3; k++) begin
            if (hit[k]) m_pend[k] = 1'b1;
            else if (ack[k]) m_pend[k] = 1'b0;
            if (setm[k]) m_en[k] = 1'b1;
            if (clrm[k]) m_en[k] = 1'b0;
         end
         m_irq = nirq;
      end
   end

   function automatic logic [31:0] exp_rdata(logic [3:0] a);
      case (a)
         4'h0:       return {29'd0, m_pend};
         4'h4, 4'h8: return {29'd0, m_en};
         default:    return 32'd0;
      endcase
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
      end
   endtask

   // every-clock comparison
   always @(posedge clk) begin
      #2;
      if (!done) begin
         chk("R8 irq_req", {31'd0, irq_req}, {31'd0, m_irq});
         if (bus_addr == 4'h0)      chk("R2 status read", bus_rdata, exp_rdata(bus_addr));
         else if (bus_addr == 4'h4 || bus_addr == 4'h8)
                                    chk("R6 enable read", bus_rdata, exp_rdata(bus_addr));
         else                       chk("R11 unmapped read", bus_rdata, exp_rdata(bus_addr));
      end
   end

   task automatic wr(logic [3:0] a, logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic pulse_flush();
      @(negedge clk); flush_done_evt = 1'b1;
      @(negedge clk); flush_done_evt = 1'b0;
   endtask

   task automatic pulse_frame();
      @(negedge clk); frame_done_evt = 1'b1;
      @(negedge clk); frame_done_evt = 1'b0;
   endtask

   task automatic look(string req, logic [3:0] a, logic [31:0] exp);
      @(negedge clk); bus_addr = a;
      @(posedge clk); #2;
      chk(req, bus_rdata, exp);
   endtask

   task automatic look_irq(string req, logic exp);
      @(posedge clk); #2;
      chk(req, {31'd0, irq_req}, {31'd0, exp});
   endtask

   initial begin
      #(8 * 200000);
      fails++;
      $display("FAIL watchdog expired");
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [15:0] lfsr;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      look("R1 status after reset", 4'h0, 32'h0);
      look("R1 enables after reset", 4'h4, 32'h0);
      look_irq("R1 irq after reset", 1'b0);

      // R10: capture while disabled
      pulse_flush();
      look("R10 latched while disabled", 4'h0, 32'h2);
      look_irq("R10 no irq while disabled", 1'b0);
      wr(4'h4, 32'hFFFF_FFF2);          // R4: only bit1 among valid bits
      look("R4 set enable bit1", 4'h8, 32'h2);
      look_irq("R10 irq after enable", 1'b1);

      // R3: zero write keeps, one write clears
      pulse_frame();
      wr(4'h0, 32'h0);
      look("R3 zero write keeps", 4'h0, 32'h6);
      wr(4'h0, 32'h2);
      look("R3 clear flush only", 4'h0, 32'h4);
      look_irq("R8 irq dropped", 1'b0);

      // R7: level held across acknowledge
      @(negedge clk); bin_oom_lvl = 1'b1;
      wr(4'h4, 32'h1);
      wr(4'h0, 32'h7);
      look("R7 oom held after ack", 4'h0, 32'h1);
      look_irq("R7 irq stays", 1'b1);
      @(negedge clk); bin_oom_lvl = 1'b0;
      look("R7 oom pending after level low", 4'h0, 32'h1);
      wr(4'h0, 32'h1);
      look("R7 oom cleared", 4'h0, 32'h0);

      // R9: event and clear in the same cycle
      pulse_flush();
      @(negedge clk);
      flush_done_evt = 1'b1; bus_addr = 4'h0; bus_wr = 1'b1; bus_wdata = 32'h2;
      @(negedge clk);
      flush_done_evt = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
      look("R9 event wins", 4'h0, 32'h2);

      // R5: clear enable bit0 only
      wr(4'h8, 32'h1);
      look("R5 clear enable bit0", 4'h4, 32'h2);

      // R11: unmapped write ignored
      wr(4'hC, 32'h7);
      look("R11 status unchanged", 4'h0, 32'h2);
      look("R11 enables unchanged", 4'h4, 32'h2);

      // bulk acknowledge
      pulse_frame();
      wr(4'h0, 32'h7);
      look("R3 bulk clear", 4'h0, 32'h0);

      // mixed stretch, model compared every clock
      lfsr = 16'hACE1;
      for (int i = 0; i < 600; i++) begin
         @(negedge clk);
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         bus_wr         = lfsr[0];
         bus_addr       = {lfsr[3:2], 2'b00};
         bus_wdata      = {24'd0, lfsr[11:4]};
         flush_done_evt = lfsr[12] & lfsr[1];
         frame_done_evt = lfsr[13] & lfsr[5];
         if (lfsr[14] & lfsr[9]) bin_oom_lvl = ~bin_oom_lvl;
      end
      @(negedge clk);
      bus_wr = 1'b0; flush_done_evt = 1'b0; frame_done_evt = 1'b0; bin_oom_lvl = 1'b0;
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule